// File: doc/BRIEF.md
# Dual-View Peripheral Register Space

This block is a small peripheral register space attached to a CPU core. The core can reach it in two ways. A short I/O view serves byte in/out requests and single-bit set, clear and test requests. A data-space view serves ordinary loads and stores. Every request is decoded into one register select, and the result comes back on a registered response one cycle later.

The space holds three general-purpose byte registers and one status register. Each status flag is set by a hardware event input and cleared by writing a one. Single-bit set and clear requests are allowed only in the low bit-addressable window. They change exactly the addressed bit, so pending flags in the same byte are never written back by accident. A third region, above the mirrored I/O range, can be reached only through loads and stores.

Top module: `ioreg_space`

## Requirements
- R1: After an active-low synchronous reset, every register and status flag reads zero, and rsp_valid, rsp_err, rsp_hit and rsp_rdata are all zero.
- R2: Byte in/out requests accept I/O addresses 0x00 to 0x3F. A larger address gives rsp_err=1 and leaves every register unchanged.
- R3: A load or store at data address A+0x20 reaches the same register as I/O address A. The status register is at I/O 0x0C, GP0 is at I/O 0x1E and GP1 is at I/O 0x2A.
- R4: Set-bit, clear-bit and test-bit requests are legal only for I/O addresses 0x00 to 0x1F. Outside that window they give rsp_err=1 and change no register.
- R5: A set-bit or clear-bit request on a general-purpose register changes only bit req_bit of that register.
- R6: A byte write to the status register clears each flag whose write-data bit is 1. Flags whose write-data bit is 0 stay as they are. Only bits 3:0 hold flags, each set by evt of the same index. Bits 7:4 always read zero.
- R7: On the status register, a set-bit request writes a one to bit req_bit and so clears only that flag. A clear-bit request writes a zero and changes no flag.
- R8: If an event and a software clear reach the same flag on the same clock edge, the flag ends up set.
- R9: Data addresses 0x60 to 0xFF form an extended region that only loads and stores can reach. GP2 is at data address 0x9C. No I/O address reaches it.
- R10: An address with no register behind it gives rsp_err=1 and rsp_rdata=0. A write to such an address is ignored. This covers data addresses below 0x20 or above 0xFF and the unused op code.
- R11: A test-bit request returns bit req_bit of the addressed register on rsp_hit. rsp_rdata is then 0.
- R12: Op codes are 0=in, 1=out, 2=load, 3=store, 4=set-bit, 5=clear-bit, 6=test-bit, and 7 is illegal. Every request gets exactly one response one cycle later. A read returns the register value from before that cycle's update. rsp_valid is low when there was no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code |
| req_addr | input | 9 | I/O address (upper bits zero) or data-space address |
| req_bit | input | 3 | Bit index for set, clear and test |
| req_wdata | input | 8 | Byte write data |
| evt | input | 8 | Hardware event inputs that set status flags |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 8 | Read data for in and load |
| rsp_hit | output | 1 | Test-bit result |
| rsp_err | output | 1 | Request rejected |

## Verification
The hardest case to reach from the ports is a status flag being set by an event on the same edge that software clears it. A second hard case is a single-bit clear landing on a byte that already holds other pending flags. The stimulus first raises several flags through idle cycles with evt driven. It then issues byte and single-bit clears with a chosen evt value on the same cycle as the request. The whole flag byte is read back afterwards, so any flag that was lost or wrongly cleared shows up in the read data.

// File: rtl/ioreg_space.sv
module ioreg_space #(
  parameter logic [7:0] FLAG_MASK = 8'h0F,
  parameter logic [5:0] STAT_IO   = 6'h0C,
  parameter logic [5:0] GP0_IO    = 6'h1E,
  parameter logic [5:0] GP1_IO    = 6'h2A,
  parameter logic [8:0] GP2_DS    = 9'h09C,
  parameter logic [8:0] DS_OFS    = 9'h020
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [2:0] req_op,
  input  logic [8:0] req_addr,
  input  logic [2:0] req_bit,
  input  logic [7:0] req_wdata,
  input  logic [7:0] evt,
  output logic       rsp_valid,
  output logic [7:0] rsp_rdata,
  output logic       rsp_hit,
  output logic       rsp_err
);
  localparam logic [8:0] IO_LAST  = 9'h03F;
  localparam logic [8:0] BIT_LAST = 9'h01F;
  localparam logic [8:0] EXT_LO   = DS_OFS + IO_LAST + 9'h001;
  localparam logic [8:0] EXT_HI   = 9'h0FF;

  localparam logic [2:0] OP_IN = 3'd0, OP_OUT = 3'd1, OP_LD = 3'd2, OP_ST = 3'd3,
                         OP_SET = 3'd4, OP_CLR = 3'd5, OP_TST = 3'd6;

  logic [7:0] stat_q, gp0_q, gp1_q, gp2_q;

  wire is_io  = (req_op == OP_IN) || (req_op == OP_OUT);
  wire is_bit = (req_op == OP_SET) || (req_op == OP_CLR) || (req_op == OP_TST);
  wire is_ds  = (req_op == OP_LD) || (req_op == OP_ST);

  wire ds_io  = is_ds && (req_addr >= DS_OFS) && (req_addr < EXT_LO);
  wire ds_ext = is_ds && (req_addr >= EXT_LO) && (req_addr <= EXT_HI);
  wire io_ok  = (is_io && req_addr <= IO_LAST) || (is_bit && req_addr <= BIT_LAST) || ds_io;

  wire [8:0] io_a = ds_io ? (req_addr - DS_OFS) : req_addr;

  wire sel_stat = io_ok && (io_a == {3'b000, STAT_IO});
  wire sel_gp0  = io_ok && (io_a == {3'b000, GP0_IO});
  wire sel_gp1  = io_ok && (io_a == {3'b000, GP1_IO});
  wire sel_gp2  = ds_ext && (req_addr == GP2_DS);
  wire mapped   = sel_stat || sel_gp0 || sel_gp1 || sel_gp2;

  wire ok     = req_valid && mapped;
  wire do_wr  = ok && ((req_op == OP_OUT) || (req_op == OP_ST));
  wire do_set = ok && (req_op == OP_SET);
  wire do_clr = ok && (req_op == OP_CLR);
  wire do_rd  = ok && ((req_op == OP_IN) || (req_op == OP_LD));
  wire do_tst = ok && (req_op == OP_TST);

  wire [7:0] bmask = 8'h01 << req_bit;

  function automatic logic [7:0] gp_next(input logic [7:0] cur, input logic sel,
                                         input logic wr, input logic st, input logic cl,
                                         input logic [7:0] wd, input logic [7:0] m);
    if (!sel)     return cur;
    else if (wr)  return wd;
    else if (st)  return cur | m;
    else if (cl)  return cur & ~m;
    else          return cur;
  endfunction

  logic [7:0] clr_mask, stat_d, rd_val;

  always_comb begin
    clr_mask = 8'h00;
    if (sel_stat && do_wr)  clr_mask = req_wdata;
    if (sel_stat && do_set) clr_mask = bmask;
    stat_d = ((stat_q & ~clr_mask) | evt) & FLAG_MASK;
  end

  always_comb begin
    rd_val = 8'h00;
    if (sel_stat) rd_val = stat_q;
    if (sel_gp0)  rd_val = gp0_q;
    if (sel_gp1)  rd_val = gp1_q;
    if (sel_gp2)  rd_val = gp2_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= 8'h00;
      gp0_q  <= 8'h00;
      gp1_q  <= 8'h00;
      gp2_q  <= 8'h00;
    end else begin
      stat_q <= stat_d;
      gp0_q  <= gp_next(gp0_q, sel_gp0, do_wr, do_set, do_clr, req_wdata, bmask);
      gp1_q  <= gp_next(gp1_q, sel_gp1, do_wr, do_set, do_clr, req_wdata, bmask);
      gp2_q  <= gp_next(gp2_q, sel_gp2, do_wr, do_set, do_clr, req_wdata, bmask);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= 8'h00;
      rsp_hit   <= 1'b0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= do_rd ? rd_val : 8'h00;
      rsp_hit   <= do_tst && rd_val[req_bit];
      rsp_err   <= req_valid && !mapped;
    end
  end
endmodule

module ioreg_space_chk #(
  parameter logic [7:0] FLAG_MASK = 8'h0F
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [2:0] req_op,
  input logic [8:0] req_addr,
  input logic [7:0] evt,
  input logic       rsp_valid,
  input logic       rsp_err,
  input logic [7:0] rsp_rdata,
  input logic       rsp_hit,
  input logic [7:0] stat_q,
  input logic [7:0] gp0_q
);
  wire bit_req  = req_valid && (req_op >= 3'd4) && (req_op <= 3'd6);
  wire io_req   = req_valid && (req_op <= 3'd1);
  wire [7:0] ev = evt & FLAG_MASK;

  // R12
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R12
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R10
  err_quiet_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_rdata == 8'h00) && !rsp_hit);
  // R2
  io_range_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req && req_addr > 9'h03F) |=> rsp_err);
  // R4
  bit_window_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_req && req_addr > 9'h01F) |=> rsp_err);
  // R4
  bit_window_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_req && req_addr > 9'h01F) |=> gp0_q == $past(gp0_q));
  // R8
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != 8'h00) |=> ((stat_q & $past(ev)) == $past(ev)));
endmodule

bind ioreg_space ioreg_space_chk #(.FLAG_MASK(FLAG_MASK)) chk_i (.*);

// File: tb/ioreg_space_tb_top.sv
module ioreg_space_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid;
  logic [2:0] req_op;
  logic [8:0] req_addr;
  logic [2:0] req_bit;
  logic [7:0] req_wdata;
  logic [7:0] evt;
  logic       rsp_valid;
  logic [7:0] rsp_rdata;
  logic       rsp_hit;
  logic       rsp_err;

  always #5 clk = ~clk;

  ioreg_space dut_i (.*);

  typedef struct {
    logic [7:0] rdata;
    logic       hit;
    logic       err;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit mon_on = 0;

  logic [7:0] m_stat = 0, m_gp0 = 0, m_gp1 = 0, m_gp2 = 0;

  task automatic fail(string tag, string what, int act, int expv);
    errors++;
    $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
  endtask

  task automatic issue(input [2:0] op, input [8:0] a, input [2:0] b,
                       input [7:0] wd, input [7:0] ev, input string tag);
    exp_t e;
    bit bad = 0;
    int io = -1;
    int sel = 0;
    logic [7:0] cur = 0;
    logic [7:0] m;
    m = 8'h01 << b;
    if (op <= 1)                 begin if (a <= 9'h3F) io = a; else bad = 1; end
    else if (op >= 4 && op <= 6) begin if (a <= 9'h1F) io = a; else bad = 1; end
    else if (op == 2 || op == 3) begin
      if (a >= 9'h20 && a <= 9'h5F) io = a - 9'h20;
      else if (a >= 9'h60 && a <= 9'hFF) sel = (a == 9'h9C) ? 4 : 0;
      else bad = 1;
    end else bad = 1;
    if (io == 'h0C) sel = 1;
    if (io == 'h1E) sel = 2;
    if (io == 'h2A) sel = 3;
    if (sel == 0) bad = 1;
    case (sel)
      1: cur = m_stat; 2: cur = m_gp0; 3: cur = m_gp1; 4: cur = m_gp2; default: cur = 0;
    endcase
    e.err   = bad;
    e.rdata = (!bad && (op == 0 || op == 2)) ? cur : 8'h00;
    e.hit   = (!bad && op == 6) ? cur[b] : 1'b0;
    e.tag   = tag;
    if (!bad) begin
      if (sel == 1) begin
        if (op == 1 || op == 3) m_stat = m_stat & ~wd;
        if (op == 4)            m_stat = m_stat & ~m;
      end else begin
        if (op == 1 || op == 3) cur = wd;
        if (op == 4)            cur = cur | m;
        if (op == 5)            cur = cur & ~m;
        if (sel == 2) m_gp0 = cur;
        if (sel == 3) m_gp1 = cur;
        if (sel == 4) m_gp2 = cur;
      end
    end
    m_stat = (m_stat | ev) & 8'h0F;
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a; req_bit = b; req_wdata = wd; evt = ev;
    exp_q.push_back(e);
  endtask

  task automatic idle(input [7:0] ev);
    m_stat = (m_stat | ev) & 8'h0F;
    @(negedge clk);
    req_valid = 0; req_op = 0; req_addr = 0; req_bit = 0; req_wdata = 0; evt = ev;
  endtask

  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      if (rsp_valid) begin
        if (exp_q.size() == 0) begin
          checks++; fail("R12", "response without request", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          checks++;
          if (rsp_err !== e.err || rsp_rdata !== e.rdata || rsp_hit !== e.hit)
            fail(e.tag, "err/rdata/hit", {rsp_err, rsp_hit, rsp_rdata}, {e.err, e.hit, e.rdata});
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R12 watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; req_op = 0; req_addr = 0; req_bit = 0; req_wdata = 0; evt = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 0 || rsp_err !== 0 || rsp_hit !== 0 || rsp_rdata !== 0)
      fail("R1", "outputs in reset", {rsp_valid, rsp_err, rsp_hit, rsp_rdata}, 0);
    rst_n = 1;
    mon_on = 1;
    // R1 reset contents
    issue(0, 9'h0C, 0, 0, 0, "R1");
    issue(0, 9'h1E, 0, 0, 0, "R1");
    issue(2, 9'h4A, 0, 0, 0, "R1");
    issue(2, 9'h9C, 0, 0, 0, "R1");
    // R3 dual views
    issue(1, 9'h1E, 0, 8'hA5, 0, "R3");
    issue(2, 9'h3E, 0, 0, 0, "R3");
    issue(3, 9'h4A, 0, 8'h3C, 0, "R3");
    issue(0, 9'h2A, 0, 0, 0, "R3");
    issue(3, 9'h3E, 0, 8'h5A, 0, "R3");
    issue(0, 9'h1E, 0, 0, 0, "R3");
    // R5 single-bit modify on GP0
    issue(4, 9'h1E, 3'd0, 8'hFF, 0, "R5");
    issue(5, 9'h1E, 3'd6, 8'h00, 0, "R5");
    issue(4, 9'h1E, 3'd7, 8'h00, 0, "R5");
    issue(0, 9'h1E, 0, 0, 0, "R5");
    // R11 bit tests
    for (int i = 0; i < 8; i++) issue(6, 9'h1E, i[2:0], 0, 0, "R11");
    issue(6, 9'h0C, 3'd1, 0, 0, "R11");
    // R4 bit ops outside window
    issue(4, 9'h2A, 3'd0, 0, 0, "R4");
    issue(5, 9'h2A, 3'd2, 0, 0, "R4");
    issue(6, 9'h20, 3'd0, 0, 0, "R4");
    issue(0, 9'h2A, 0, 0, 0, "R4");
    // R2 in/out range
    issue(1, 9'h40, 0, 8'h11, 0, "R2");
    issue(0, 9'h45, 0, 0, 0, "R2");
    issue(1, 9'h6A, 0, 8'h11, 0, "R2");
    issue(0, 9'h2A, 0, 0, 0, "R2");
    // R6 write-one-to-clear and reserved bits
    idle(8'hFF);
    idle(8'h00);
    issue(0, 9'h0C, 0, 0, 0, "R6");
    issue(1, 9'h0C, 0, 8'h00, 0, "R6");
    issue(0, 9'h0C, 0, 0, 0, "R6");
    issue(3, 9'h2C, 0, 8'h03, 0, "R6");
    issue(2, 9'h2C, 0, 0, 0, "R6");
    issue(1, 9'h0C, 0, 8'hF0, 8'hF0, "R6");
    issue(0, 9'h0C, 0, 0, 0, "R6");
    // R7 bit ops on status
    idle(8'h0F);
    issue(4, 9'h0C, 3'd2, 0, 0, "R7");
    issue(0, 9'h0C, 0, 0, 0, "R7");
    issue(5, 9'h0C, 3'd0, 0, 0, "R7");
    issue(0, 9'h0C, 0, 0, 0, "R7");
    // R8 event beats clear
    issue(1, 9'h0C, 0, 8'h01, 8'h01, "R8");
    issue(0, 9'h0C, 0, 0, 0, "R8");
    issue(4, 9'h0C, 3'd3, 0, 8'h08, "R8");
    issue(4, 9'h0C, 3'd1, 0, 8'h04, "R8");
    issue(0, 9'h0C, 0, 0, 0, "R8");
    issue(1, 9'h0C, 0, 8'hFF, 0, "R8");
    issue(0, 9'h0C, 0, 0, 0, "R8");
    // R9 extended region
    issue(3, 9'h9C, 0, 8'h77, 0, "R9");
    issue(2, 9'h9C, 0, 0, 0, "R9");
    issue(0, 9'h7C, 0, 0, 0, "R9");
    issue(1, 9'h3C, 0, 8'hEE, 0, "R9");
    issue(2, 9'h9C, 0, 0, 0, "R9");
    // R10 reserved addresses and illegal op
    issue(1, 9'h10, 0, 8'h99, 0, "R10");
    issue(0, 9'h10, 0, 0, 0, "R10");
    issue(2, 9'h9D, 0, 0, 0, "R10");
    issue(3, 9'h130, 0, 8'h12, 0, "R10");
    issue(2, 9'h005, 0, 0, 0, "R10");
    issue(3, 9'h01E, 0, 8'h00, 0, "R10");
    issue(7, 9'h1E, 0, 8'h00, 0, "R10");
    issue(0, 9'h1E, 0, 0, 0, "R10");
    issue(2, 9'h9C, 0, 0, 0, "R10");
    // R12 gaps between requests
    idle(0);
    idle(0);
    issue(0, 9'h2A, 0, 0, 0, "R12");
    idle(0);
    issue(2, 9'h3E, 0, 0, 0, "R12");
    idle(0);
    idle(0);
    idle(0);
    checks++;
    if (exp_q.size() != 0) fail("R12", "missing responses", exp_q.size(), 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule